// File: doc/BRIEF.md
# Accumulator ALU with Registered Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle the sequencer may pulse a strobe together with a 4-bit operation code, a register operand (normally the accumulator or an index register) and a memory operand. On the clock edge that samples the strobe, the block writes an 8-bit result register and the negative, zero, carry and overflow flags. With no strobe, nothing moves.

The carry used by add, subtract and the carry-dependent rules is the block's own registered carry flag, so a chain of operations passes carry from one to the next with no external wiring. All arithmetic is plain binary. Single-operand operations (increment, decrement, shifts and rotates) take their input from either operand port, chosen by a select line. Compare updates flags only, and the result register keeps its value.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a clock edge, the result register and all four flags are cleared to 0.
- R2: Result and flags change only on a rising edge where `op_valid` is 1. The new values are visible after that edge. With `op_valid` at 0 they hold, whatever the other inputs do.
- R3: Code 0x0 (add) writes reg + mem + C mod 256. C becomes the carry out of the 9-bit sum. The add is binary only, so 0x09 + 0x01 with C=0 gives 0x0A.
- R4: Code 0x1 (subtract) writes reg − mem − (1 − C) mod 256. C becomes 1 when no borrow occurs and 0 when one does.
- R5: After add or subtract, V is 1 exactly when the signed result leaves the range −128..127. Put another way, V is set when the two effective operand signs match (for subtract, the memory operand inverted) and the result sign differs from them.
- R6: Every operation that writes the result sets N to result bit 7 and sets Z to 1 when the result is 0x00.
- R7: Codes 0x2 (AND), 0x3 (OR) and 0x4 (XOR) combine reg with mem. Code 0xC (load) writes mem unchanged. None of these four alters C or V.
- R8: Codes 0x5 (increment) and 0x6 (decrement) add or subtract 1 with wrap-around (0xFF to 0x00, 0x00 to 0xFF) and leave C and V unchanged. `unary_src` = 0 selects `reg_opnd` and `unary_src` = 1 selects `mem_opnd`, for codes 0x5 to 0xA.
- R9: Code 0x7 shifts left, filling with 0 and moving bit 7 into C. Code 0x8 shifts right, filling with 0 and moving bit 0 into C. V is unchanged.
- R10: Code 0x9 rotates left by one, so bit 7 re-enters at bit 0 and is copied to C. Code 0xA rotates right by one, so bit 0 re-enters at bit 7 and is copied to C. The old carry does not enter the value, and V is unchanged.
- R11: Code 0xB (compare reg with mem, unsigned) sets N only when reg < mem, sets Z and C when they are equal, and sets only C when reg > mem. V and the result register are unchanged.
- R12: Codes 0xD, 0xE and 0xF change neither the result nor any flag, even when strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| unary_src | input | 1 | Operand select for single-operand ops (0 reg, 1 mem) |
| reg_opnd | input | 8 | Register operand |
| mem_opnd | input | 8 | Memory operand |
| result_q | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets the carry edges.

- It runs 0xFF + 0xFF with carry in. A design that detects carry by comparing the result against the operands would drop this carry.
- It runs 0x00 − 0x00 with carry set, which must keep C at 1. A design with inverted borrow sense would clear it.

It also covers these signed and encoding corners:

- It runs 0x7F + 0x01 and 0x80 − 0x01 to expose overflow logic that looks at the wrong operand sign.
- It runs 0x09 + 0x01, which shows whether the add applies a decimal adjust.

The last group covers operand selection and flag retention:

- Rotates run with the opposite carry already set, so a rotate that goes through carry would show a wrong bit 0 or bit 7.
- Compare runs with a result already held, to catch a compare that overwrites it.
- Logic, increment and load run after C and V have been set, to catch flags that are cleared where they should be kept.
- A mixed pseudo-random sweep exercises operand selection and the reserved codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADC = 4'h0,
    OP_SBC = 4'h1,
    OP_AND = 4'h2,
    OP_OR  = 4'h3,
    OP_XOR = 4'h4,
    OP_INC = 4'h5,
    OP_DEC = 4'h6,
    OP_ASL = 4'h7,
    OP_LSR = 4'h8,
    OP_ROL = 4'h9,
    OP_ROR = 4'hA,
    OP_CMP = 4'hB,
    OP_LD  = 4'hC
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_ASL = 2'd0,
    SH_LSR = 2'd1,
    SH_ROL = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  // subtract reuses the adder: a + ~b + cin == a - b - (1 - cin)
  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  end

  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  assign ovf  = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);

endmodule

// File: rtl/alu8_incdec.sv
module alu8_incdec #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic         dec,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (dec) y = x - ONE;
    else     y = x + ONE;
  end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  shift_kind_e  kind,
  output logic [W-1:0] y,
  output logic         cout
);
  localparam int MSB = W - 1;

  logic [W-1:0] from_below;
  logic [W-1:0] from_above;
  logic         fill_lo;
  logic         fill_hi;
  logic         go_left;

  assign go_left = (kind == SH_ASL) || (kind == SH_ROL);
  assign fill_lo = (kind == SH_ROL) ? x[MSB] : 1'b0;
  assign fill_hi = (kind == SH_ROR) ? x[0]   : 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_lane
    if (g == 0) begin : g_lo
      assign from_below[g] = fill_lo;
    end else begin : g_lo_mid
      assign from_below[g] = x[g-1];
    end
    if (g == MSB) begin : g_hi
      assign from_above[g] = fill_hi;
    end else begin : g_hi_mid
      assign from_above[g] = x[g+1];
    end
  end

  assign y    = go_left ? from_below : from_above;
  assign cout = go_left ? x[MSB] : x[0];

endmodule

// File: rtl/alu8_compare.sv
module alu8_compare #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         lt,
  output logic         eq
);
  assign lt = lhs < rhs;
  assign eq = lhs == rhs;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic         unary_src,
  input  logic [W-1:0] reg_opnd,
  input  logic [W-1:0] mem_opnd,
  output logic [W-1:0] result_q,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int MSB = W - 1;

  alu_op_e      op;
  alu_flags_t   flags_q, flags_d;
  logic [W-1:0] result_d;
  logic [W-1:0] uny_x;
  logic [W-1:0] as_sum, id_y, sh_y;
  logic         as_cout, as_ovf, sh_cout, cmp_lt, cmp_eq;
  logic         writes_result;
  shift_kind_e  sh_kind;

  assign op    = alu_op_e'(op_code);
  assign uny_x = unary_src ? mem_opnd : reg_opnd;

  always_comb begin
    case (op)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ROL:  sh_kind = SH_ROL;
      OP_ROR:  sh_kind = SH_ROR;
      default: sh_kind = SH_ASL;
    endcase
  end

  alu8_addsub #(.W(W)) addsub_i (
    .a(reg_opnd), .b(mem_opnd), .cin(flags_q.c), .sub(op == OP_SBC),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu8_incdec #(.W(W)) incdec_i (
    .x(uny_x), .dec(op == OP_DEC), .y(id_y)
  );

  alu8_shifter #(.W(W)) shifter_i (
    .x(uny_x), .kind(sh_kind), .y(sh_y), .cout(sh_cout)
  );

  alu8_compare #(.W(W)) compare_i (
    .lhs(reg_opnd), .rhs(mem_opnd), .lt(cmp_lt), .eq(cmp_eq)
  );

  always_comb begin
    result_d      = result_q;
    flags_d       = flags_q;
    writes_result = 1'b0;
    case (op)
      OP_ADC, OP_SBC: begin
        result_d      = as_sum;
        flags_d.c     = as_cout;
        flags_d.v     = as_ovf;
        writes_result = 1'b1;
      end
      OP_AND: begin result_d = reg_opnd & mem_opnd; writes_result = 1'b1; end
      OP_OR:  begin result_d = reg_opnd | mem_opnd; writes_result = 1'b1; end
      OP_XOR: begin result_d = reg_opnd ^ mem_opnd; writes_result = 1'b1; end
      OP_INC, OP_DEC: begin
        result_d      = id_y;
        writes_result = 1'b1;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        result_d      = sh_y;
        flags_d.c     = sh_cout;
        writes_result = 1'b1;
      end
      OP_CMP: begin
        flags_d.n = cmp_lt;
        flags_d.z = cmp_eq;
        flags_d.c = ~cmp_lt;
      end
      OP_LD: begin result_d = mem_opnd; writes_result = 1'b1; end
      default: ;
    endcase
    if (writes_result) begin
      flags_d.n = result_d[MSB];
      flags_d.z = (result_d == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (op_valid) begin
      result_q <= result_d;
      flags_q  <= flags_d;
    end
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic         unary_src,
  input logic [W-1:0] reg_opnd,
  input logic [W-1:0] mem_opnd,
  input logic [W-1:0] result_q,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_v
);
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(result_q) && $stable({flag_n, flag_z, flag_c, flag_v}));

  a_r3_add_carry_chain: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'h0) |=>
      {flag_c, result_q} == ({1'b0, $past(reg_opnd)} + {1'b0, $past(mem_opnd)}
                             + {{W{1'b0}}, $past(flag_c)}));

  a_r6_nz_follow: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code <= 4'hA || op_code == 4'hC)) |=>
      (flag_n == result_q[MSB]) && (flag_z == (result_q == '0)));

  a_r7_logic_keeps_cv: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code inside {4'h2, 4'h3, 4'h4, 4'hC})) |=>
      $stable({flag_c, flag_v}));

  a_r8_inc_src: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'h5) |=>
      result_q == (($past(unary_src) ? $past(mem_opnd) : $past(reg_opnd)) + ONE));

  a_r11_cmp_flags: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'hB) |=>
      (flag_c == ($past(reg_opnd) >= $past(mem_opnd))) && !(flag_n && flag_z)
      && $stable(result_q) && $stable(flag_v));

  a_r12_reserved_inert: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > 4'hC) |=>
      $stable(result_q) && $stable({flag_n, flag_z, flag_c, flag_v}));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .unary_src(unary_src), .reg_opnd(reg_opnd), .mem_opnd(mem_opnd),
  .result_q(result_q), .flag_n(flag_n), .flag_z(flag_z),
  .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'h0;
  logic       unary_src = 1'b0;
  logic [7:0] reg_opnd = 8'h00;
  logic [7:0] mem_opnd = 8'h00;
  logic [7:0] result_q;
  logic       flag_n, flag_z, flag_c, flag_v;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] e_res = 8'h00;
  logic e_n = 1'b0, e_z = 1'b0, e_c = 1'b0, e_v = 1'b0;

  always #5 clk = ~clk;

  alu8_core #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .unary_src(unary_src), .reg_opnd(reg_opnd), .mem_opnd(mem_opnd),
    .result_q(result_q), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check_state(input string tag);
    n_chk++;
    if ({result_q, flag_n, flag_z, flag_c, flag_v} !== {e_res, e_n, e_z, e_c, e_v}) begin
      n_bad++;
      $display("FAIL %s: got res=%02h nzcv=%b%b%b%b, expected res=%02h nzcv=%b%b%b%b",
               tag, result_q, flag_n, flag_z, flag_c, flag_v, e_res, e_n, e_z, e_c, e_v);
    end
  endtask

  // independent reference built from the requirement text
  task automatic model(input logic [3:0] op, input logic src, input logic [7:0] r, input logic [7:0] m);
    logic [7:0] x;
    int s;
    int sv;
    logic wr;
    x  = src ? m : r;
    wr = 1'b1;
    case (op)
      4'h0: begin
        s  = int'(r) + int'(m) + int'(e_c);
        sv = int'($signed(r)) + int'($signed(m)) + int'(e_c);
        e_res = s[7:0]; e_c = (s > 255); e_v = (sv > 127) || (sv < -128);
      end
      4'h1: begin
        s  = int'(r) - int'(m) - (1 - int'(e_c));
        sv = int'($signed(r)) - int'($signed(m)) - (1 - int'(e_c));
        e_res = s[7:0]; e_c = (s >= 0); e_v = (sv > 127) || (sv < -128);
      end
      4'h2: e_res = r & m;
      4'h3: e_res = r | m;
      4'h4: e_res = r ^ m;
      4'h5: e_res = x + 8'd1;
      4'h6: e_res = x - 8'd1;
      4'h7: begin e_c = x[7]; e_res = {x[6:0], 1'b0}; end
      4'h8: begin e_c = x[0]; e_res = {1'b0, x[7:1]}; end
      4'h9: begin e_c = x[7]; e_res = {x[6:0], x[7]}; end
      4'hA: begin e_c = x[0]; e_res = {x[0], x[7:1]}; end
      4'hB: begin wr = 1'b0; e_n = (r < m); e_z = (r == m); e_c = (r >= m); end
      4'hC: e_res = m;
      default: wr = 1'b0;
    endcase
    if (wr) begin
      e_n = e_res[7];
      e_z = (e_res == 8'h00);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic src, input logic [7:0] r,
                       input logic [7:0] m, input string tag);
    @(negedge clk);
    op_code = op; unary_src = src; reg_opnd = r; mem_opnd = m; op_valid = 1'b1;
    model(op, src, r, m);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check_state(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_res = 8'h00; e_n = 0; e_z = 0; e_c = 0; e_v = 0;
    check_state("R1 reset");
  endtask

  task automatic t_idle();
    apply(4'hC, 1'b0, 8'h00, 8'hA5, "R2 load before idle");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_code = 4'h0; reg_opnd = 8'(i * 37); mem_opnd = 8'hFF; unary_src = i[0];
      @(posedge clk);
      #1 check_state("R2 idle hold");
    end
    @(negedge clk);
    op_code = 4'h3; reg_opnd = 8'h0F; mem_opnd = 8'hF0; op_valid = 1'b1;
    #2 check_state("R2 no change before edge");
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    model(4'h3, 1'b0, 8'h0F, 8'hF0);
    check_state("R2 update after edge");
  endtask

  task automatic t_add();
    apply(4'hB, 0, 8'h01, 8'h02, "R11 clear carry");
    apply(4'h0, 0, 8'h10, 8'h20, "R3 plain add");
    apply(4'h0, 0, 8'h09, 8'h01, "R3 binary not decimal");
    apply(4'h0, 0, 8'hFF, 8'h01, "R3 carry out zero result R6");
    apply(4'h0, 0, 8'hFF, 8'hFF, "R3 add ff+ff with carry in");
    apply(4'h0, 0, 8'h7F, 8'h01, "R5 positive overflow");
    apply(4'h0, 0, 8'h80, 8'h80, "R5 negative overflow");
  endtask

  task automatic t_sub();
    apply(4'hB, 0, 8'h05, 8'h05, "R11 set carry");
    apply(4'h1, 0, 8'h05, 8'h03, "R4 no borrow");
    apply(4'h1, 0, 8'h00, 8'h00, "R4 zero minus zero keeps carry");
    apply(4'h1, 0, 8'h03, 8'h05, "R4 borrow");
    apply(4'h1, 0, 8'h05, 8'h03, "R4 borrow in consumed");
    apply(4'hB, 0, 8'h05, 8'h05, "R11 set carry");
    apply(4'h1, 0, 8'h80, 8'h01, "R5 subtract overflow");
  endtask

  task automatic t_logic();
    apply(4'h0, 0, 8'h7F, 8'h7F, "R5 set V");
    apply(4'hB, 0, 8'h09, 8'h01, "R11 set C");
    apply(4'h2, 0, 8'hF0, 8'h3C, "R7 and keeps CV");
    apply(4'h3, 0, 8'h00, 8'h00, "R7 or zero");
    apply(4'h4, 0, 8'hAA, 8'h55, "R7 xor");
    apply(4'hC, 0, 8'h11, 8'h00, "R7 load zero");
  endtask

  task automatic t_incdec();
    apply(4'h5, 0, 8'hFF, 8'h10, "R8 inc wrap from reg");
    apply(4'h5, 1, 8'hFF, 8'h10, "R8 inc from mem");
    apply(4'h6, 0, 8'h00, 8'h42, "R8 dec wrap");
    apply(4'h6, 1, 8'h00, 8'h81, "R8 dec from mem");
  endtask

  task automatic t_shift();
    apply(4'h7, 0, 8'h81, 8'h00, "R9 asl carry out");
    apply(4'h7, 1, 8'h00, 8'h80, "R9 asl to zero from mem");
    apply(4'h8, 0, 8'h01, 8'hFF, "R9 lsr to zero");
    apply(4'h8, 0, 8'hFE, 8'h00, "R9 lsr no carry");
  endtask

  task automatic t_rot();
    apply(4'hB, 0, 8'h01, 8'h02, "R11 clear carry");
    apply(4'h9, 0, 8'h80, 8'h00, "R10 rol wraps bit7");
    apply(4'hB, 0, 8'h03, 8'h02, "R11 set carry");
    apply(4'h9, 0, 8'h40, 8'h00, "R10 rol ignores old carry");
    apply(4'hA, 1, 8'h00, 8'h01, "R10 ror wraps bit0");
    apply(4'hB, 0, 8'h03, 8'h02, "R11 set carry");
    apply(4'hA, 0, 8'h02, 8'h00, "R10 ror ignores old carry");
  endtask

  task automatic t_cmp();
    apply(4'hC, 0, 8'h00, 8'h5A, "R7 load before compare");
    apply(4'hB, 0, 8'h10, 8'h20, "R11 less");
    apply(4'hB, 0, 8'h20, 8'h20, "R11 equal");
    apply(4'hB, 0, 8'hF0, 8'h20, "R11 greater unsigned");
  endtask

  task automatic t_reserved();
    apply(4'hC, 0, 8'h00, 8'h80, "R7 load before reserved");
    apply(4'hD, 0, 8'h00, 8'h00, "R12 code d");
    apply(4'hE, 1, 8'hFF, 8'hFF, "R12 code e");
    apply(4'hF, 0, 8'h01, 8'h7F, "R12 code f");
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[3:0], lfsr[4], lfsr[15:8], {lfsr[7:5], lfsr[12:8]}, "SWEEP mixed ops");
    end
  endtask

  initial begin
    t_reset();
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_shift();
    t_rot();
    t_cmp();
    t_reserved();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule